// File: doc/BRIEF.md
# Masked Lane-Wise Vector Interleave Unit

This block is a one-stage registered datapath for a vector unit. It takes two vector operands of up to 512 bits and treats every element as a raw 32-bit pattern. Each 128-bit lane is handled on its own. The unit takes the two lowest elements of that lane from both operands and alternates them into the result. The upper two elements of each lane are dropped. Nothing moves between lanes.

A control word selects how the result is formed:

- The vector length: 128, 256 or 512 bits.
- The mode: legacy, plain, or masked.
- In masked mode, a per-element write mask, a merge-or-zero choice, and a broadcast of the second operand's lowest element.

The caller supplies the previous destination value on its own input. Masked-off elements can then keep their old contents. In legacy mode, the bits above 128 also pass through unchanged.

Top module: `vil_unit`

## Requirements
- R1: Element e occupies bits 32e+31:32e. For lane l, result elements 4l, 4l+1, 4l+2 and 4l+3 are, in that order, A element 4l, B element 4l, A element 4l+1 and B element 4l+1.
- R2: Elements 4l+2 and 4l+3 of either source never influence the result, and no element moves to a different lane.
- R3: `vlen_i` code 0 selects 128 bits (4 elements), code 1 selects 256 bits (8 elements), and codes 2 and 3 select 512 bits (16 elements).
- R4: In plain and masked mode, every result bit at or above the selected vector length is zero.
- R5: In masked mode with `bcast_i` high, every element of B is replaced by B element 0 before the interleave.
- R6: In masked mode (`mode_i` = 2), an active element j whose `mask_i[j]` is 1 takes the interleaved value. If `mask_i[j]` is 0, the element keeps old element j when `merge_i` is 1, and becomes zero when `merge_i` is 0.
- R7: In plain mode (`mode_i` = 1 or 3), every active element takes the interleaved value, and `mask_i`, `merge_i` and `bcast_i` have no effect.
- R8: In legacy mode (`mode_i` = 0), elements 0 to 3 are the interleave of lane 0, and bits 511:128 equal the same bits of `old_i`. `vlen_i`, `mask_i`, `merge_i` and `bcast_i` have no effect.
- R9: Mask bits at or above the active element count have no effect.
- R10: A result accepted with `vld_i` high appears on `res_o` one cycle later, with `vld_o` high. `vld_o` is low one cycle after a cycle with `vld_i` low, and `res_o` holds its value.
- R11: A synchronous active-high `rst` clears `vld_o` and `res_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| vld_i | input | 1 | Operands valid this cycle |
| vlen_i | input | 2 | Vector length code |
| mode_i | input | 2 | 0 legacy, 1 plain, 2 masked, 3 plain |
| mask_i | input | 16 | Per-element write mask |
| merge_i | input | 1 | 1 merge old value, 0 zero masked-off elements |
| bcast_i | input | 1 | Broadcast B element 0 in masked mode |
| src_a_i | input | 512 | First source (also destination in legacy mode) |
| src_b_i | input | 512 | Second source |
| old_i | input | 512 | Previous destination value |
| vld_o | output | 1 | Result valid |
| res_o | output | 512 | Registered result |

## Verification
The bench builds the unit with its default of four lanes, so the 512-bit length and all 16 mask bits are live. This lets one build reach every vector-length code and every mode code.

Each combination of length, mode, broadcast and merge flag is swept with all-zero, all-one and several random masks on random data. The results are compared with a loop-based reference model. Dedicated vectors vary only the upper lane elements, only the out-of-range mask bits, and only the ignored controls, to show that they have no effect.

// File: rtl/vil_pkg.sv
package vil_pkg;
    localparam int EW     = 32;
    localparam int LANE_E = 4;

    typedef enum logic [1:0] {
        MD_LEGACY = 2'd0,
        MD_PLAIN  = 2'd1,
        MD_MASKED = 2'd2,
        MD_ALT    = 2'd3
    } mode_e;

    function automatic int lanes_for(input logic [1:0] vl, input int max_lanes);
        int n;
        case (vl)
            2'd0:    n = 1;
            2'd1:    n = 2;
            default: n = 4;
        endcase
        return (n > max_lanes) ? max_lanes : n;
    endfunction
endpackage

// File: rtl/vil_bcast.sv
module vil_bcast #(
    parameter int NLANE = 4,
    localparam int NEL = NLANE * vil_pkg::LANE_E,
    localparam int VW  = NEL * vil_pkg::EW
) (
    input  logic          en,
    input  logic [VW-1:0] src,
    output logic [VW-1:0] dst
);
    localparam int EW = vil_pkg::EW;

    for (genvar e = 0; e < NEL; e++) begin : g_el
        assign dst[e*EW +: EW] = en ? src[EW-1:0] : src[e*EW +: EW];
    end
endmodule

// File: rtl/vil_lane_mix.sv
module vil_lane_mix #(
    parameter int NLANE = 4,
    localparam int NEL = NLANE * vil_pkg::LANE_E,
    localparam int VW  = NEL * vil_pkg::EW
) (
    input  logic [VW-1:0] a,
    input  logic [VW-1:0] b,
    output logic [VW-1:0] mix
);
    localparam int EW = vil_pkg::EW;
    localparam int LW = vil_pkg::LANE_E * EW;

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        assign mix[l*LW + 0*EW +: EW] = a[l*LW + 0*EW +: EW];
        assign mix[l*LW + 1*EW +: EW] = b[l*LW + 0*EW +: EW];
        assign mix[l*LW + 2*EW +: EW] = a[l*LW + 1*EW +: EW];
        assign mix[l*LW + 3*EW +: EW] = b[l*LW + 1*EW +: EW];
    end
endmodule

// File: rtl/vil_elem_sel.sv
module vil_elem_sel #(
    parameter int NLANE = 4,
    localparam int NEL = NLANE * vil_pkg::LANE_E,
    localparam int VW  = NEL * vil_pkg::EW
) (
    input  logic [VW-1:0]  mix,
    input  logic [VW-1:0]  old,
    input  logic [NEL-1:0] take_new,
    input  logic [NEL-1:0] take_old,
    output logic [VW-1:0]  res
);
    localparam int EW = vil_pkg::EW;

    for (genvar e = 0; e < NEL; e++) begin : g_el
        always_comb begin
            if (take_new[e])
                res[e*EW +: EW] = mix[e*EW +: EW];
            else if (take_old[e])
                res[e*EW +: EW] = old[e*EW +: EW];
            else
                res[e*EW +: EW] = '0;
        end
    end
endmodule

// File: rtl/vil_unit.sv
module vil_unit #(
    parameter int NLANE = 4,
    localparam int NEL = NLANE * vil_pkg::LANE_E,
    localparam int VW  = NEL * vil_pkg::EW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           vld_i,
    input  logic [1:0]     vlen_i,
    input  logic [1:0]     mode_i,
    input  logic [NEL-1:0] mask_i,
    input  logic           merge_i,
    input  logic           bcast_i,
    input  logic [VW-1:0]  src_a_i,
    input  logic [VW-1:0]  src_b_i,
    input  logic [VW-1:0]  old_i,
    output logic           vld_o,
    output logic [VW-1:0]  res_o
);
    import vil_pkg::*;

    typedef struct packed {
        logic          vld;
        logic [VW-1:0] res;
    } st_t;

    st_t st_d, st_q;

    logic           is_legacy, is_masked;
    logic [VW-1:0]  b_eff, mix, sel;
    logic [NEL-1:0] take_new, take_old;

    assign is_legacy = (mode_e'(mode_i) == MD_LEGACY);
    assign is_masked = (mode_e'(mode_i) == MD_MASKED);

    vil_bcast #(.NLANE(NLANE)) u_bc (
        .en  (is_masked & bcast_i),
        .src (src_b_i),
        .dst (b_eff)
    );

    vil_lane_mix #(.NLANE(NLANE)) u_mix (
        .a   (src_a_i),
        .b   (b_eff),
        .mix (mix)
    );

    always_comb begin
        int nact;
        nact = lanes_for(vlen_i, NLANE) * LANE_E;
        for (int e = 0; e < NEL; e++) begin
            if (is_legacy) begin
                take_new[e] = (e < LANE_E);
                take_old[e] = (e >= LANE_E);
            end else if (is_masked) begin
                take_new[e] = (e < nact) && mask_i[e];
                take_old[e] = (e < nact) && !mask_i[e] && merge_i;
            end else begin
                take_new[e] = (e < nact);
                take_old[e] = 1'b0;
            end
        end
    end

    vil_elem_sel #(.NLANE(NLANE)) u_sel (
        .mix      (mix),
        .old      (old_i),
        .take_new (take_new),
        .take_old (take_old),
        .res      (sel)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = vld_i;
        if (vld_i)
            st_d.res = sel;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign vld_o = st_q.vld;
    assign res_o = st_q.res;
endmodule

// File: rtl/vil_unit_chk.sv
module vil_unit_chk #(
    parameter int NEL = 16,
    parameter int VW  = 512
) (
    input logic           clk,
    input logic           rst,
    input logic           vld_i,
    input logic [1:0]     vlen_i,
    input logic [1:0]     mode_i,
    input logic [NEL-1:0] mask_i,
    input logic           merge_i,
    input logic [VW-1:0]  src_a_i,
    input logic [VW-1:0]  src_b_i,
    input logic [VW-1:0]  old_i,
    input logic           vld_o,
    input logic [VW-1:0]  res_o
);
    a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
        vld_i |=> vld_o);

    a_r10_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !vld_i |=> (!vld_o && $stable(res_o)));

    a_r8_legacy_upper: assert property (@(posedge clk) disable iff (rst)
        (vld_i && mode_i == 2'd0) |=> (res_o[VW-1:128] == $past(old_i[VW-1:128])));

    a_r4_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (vld_i && mode_i != 2'd0 && vlen_i == 2'd0) |=> (res_o[VW-1:128] == '0));

    a_r1_low_pair: assert property (@(posedge clk) disable iff (rst)
        (vld_i && mode_i == 2'd1) |=>
            (res_o[31:0] == $past(src_a_i[31:0]) && res_o[63:32] == $past(src_b_i[31:0])));

    a_r6_zeroing: assert property (@(posedge clk) disable iff (rst)
        (vld_i && mode_i == 2'd2 && !merge_i && !mask_i[0]) |=> (res_o[31:0] == '0));

    a_r11_reset: assert property (@(posedge clk)
        rst |=> (!vld_o && res_o == '0));
endmodule

bind vil_unit vil_unit_chk #(.NEL(NEL), .VW(VW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .vld_i   (vld_i),
    .vlen_i  (vlen_i),
    .mode_i  (mode_i),
    .mask_i  (mask_i),
    .merge_i (merge_i),
    .src_a_i (src_a_i),
    .src_b_i (src_b_i),
    .old_i   (old_i),
    .vld_o   (vld_o),
    .res_o   (res_o)
);

// File: tb/sim_vil_unit.sv
module sim_vil_unit;
    localparam int CLK_PER = 10;
    localparam int NEL = 16;
    localparam int VW  = 512;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           vld_i = 1'b0;
    logic [1:0]     vlen_i = '0;
    logic [1:0]     mode_i = '0;
    logic [NEL-1:0] mask_i = '0;
    logic           merge_i = 1'b0;
    logic           bcast_i = 1'b0;
    logic [VW-1:0]  src_a_i = '0;
    logic [VW-1:0]  src_b_i = '0;
    logic [VW-1:0]  old_i = '0;
    logic           vld_o;
    logic [VW-1:0]  res_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PER/2) clk = ~clk;

    vil_unit u0 (
        .clk(clk), .rst(rst), .vld_i(vld_i), .vlen_i(vlen_i), .mode_i(mode_i),
        .mask_i(mask_i), .merge_i(merge_i), .bcast_i(bcast_i),
        .src_a_i(src_a_i), .src_b_i(src_b_i), .old_i(old_i),
        .vld_o(vld_o), .res_o(res_o)
    );

    function automatic logic [VW-1:0] rnd_vec();
        logic [VW-1:0] v;
        for (int e = 0; e < NEL; e++) v[e*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [VW-1:0] model(
        input logic [VW-1:0] a, input logic [VW-1:0] b, input logic [VW-1:0] od,
        input logic [1:0] vl, input logic [1:0] md, input logic [NEL-1:0] mk,
        input logic mg, input logic bc);
        logic [VW-1:0] r;
        int nact;
        nact = (vl == 2'd0) ? 4 : (vl == 2'd1) ? 8 : 16;
        for (int j = 0; j < NEL; j++) begin
            int lane, pos, src;
            logic [31:0] t;
            lane = j / 4;
            pos  = j % 4;
            src  = lane * 4 + pos / 2;
            if (pos % 2 == 0) t = a[src*32 +: 32];
            else if (md == 2'd2 && bc) t = b[31:0];
            else t = b[src*32 +: 32];
            if (md == 2'd0)
                r[j*32 +: 32] = (j < 4) ? t : od[j*32 +: 32];
            else if (j >= nact)
                r[j*32 +: 32] = '0;
            else if (md == 2'd2 && !mk[j])
                r[j*32 +: 32] = mg ? od[j*32 +: 32] : 32'd0;
            else
                r[j*32 +: 32] = t;
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic check1(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%b exp=%b", tag, act, exp);
        end
    endtask

    task automatic apply(input string tag, input logic [VW-1:0] a, input logic [VW-1:0] b,
                         input logic [VW-1:0] od, input logic [1:0] vl, input logic [1:0] md,
                         input logic [NEL-1:0] mk, input logic mg, input logic bc);
        @(negedge clk);
        vld_i = 1'b1; src_a_i = a; src_b_i = b; old_i = od;
        vlen_i = vl; mode_i = md; mask_i = mk; merge_i = mg; bcast_i = bc;
        @(negedge clk);
        vld_i = 1'b0;
        check1({tag, " R10 vld"}, vld_o, 1'b1);
        check(tag, res_o, model(a, b, od, vl, md, mk, mg, bc));
    endtask

    initial begin
        #(CLK_PER * 200000);
        n_bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [VW-1:0] a, b, od, b2, r0;
        logic [NEL-1:0] masks [6];
        repeat (3) @(negedge clk);
        check1("R11 reset vld", vld_o, 1'b0);
        check("R11 reset res", res_o, '0);
        rst = 1'b0;

        // Interleave order, fixed pattern: element e of A = 0xA00+e, B = 0xB00+e (R1)
        for (int e = 0; e < NEL; e++) begin
            a[e*32 +: 32] = 32'hA00 + e;
            b[e*32 +: 32] = 32'hB00 + e;
        end
        od = rnd_vec();
        apply("R1 order", a, b, od, 2'd2, 2'd1, '0, 1'b0, 1'b0);
        check("R1 lane3 literal", res_o[511:384], {32'hB0D, 32'hA0D, 32'hB0C, 32'hA0C});

        masks[0] = '0; masks[1] = '1;
        for (int vl = 0; vl < 4; vl++)
            for (int md = 0; md < 4; md++)
                for (int bc = 0; bc < 2; bc++)
                    for (int mg = 0; mg < 2; mg++) begin
                        string tg;
                        for (int k = 2; k < 6; k++) masks[k] = NEL'($urandom);
                        if (md == 0) tg = "R8 legacy";
                        else if (md == 2 && bc == 1) tg = "R5 bcast masked";
                        else if (md == 2) tg = "R6 masked";
                        else tg = "R7 plain";
                        tg = $sformatf("%s R3 R4 vl=%0d", tg, vl);
                        for (int k = 0; k < 6; k++)
                            apply(tg, rnd_vec(), rnd_vec(), rnd_vec(), 2'(vl), 2'(md),
                                  masks[k], 1'(mg), 1'(bc));
                    end

        // Upper lane elements must not matter (R2)
        a = rnd_vec(); b = rnd_vec(); od = rnd_vec();
        apply("R2 base", a, b, od, 2'd2, 2'd2, 16'h5A3C, 1'b1, 1'b0);
        r0 = res_o;
        for (int l = 0; l < 4; l++) begin
            a[(l*4+2)*32 +: 64] = ~a[(l*4+2)*32 +: 64];
            b[(l*4+2)*32 +: 64] = ~b[(l*4+2)*32 +: 64];
        end
        apply("R2 upper elems flipped", a, b, od, 2'd2, 2'd2, 16'h5A3C, 1'b1, 1'b0);
        check("R2 unchanged", res_o, r0);

        // Mask bits beyond active count (R9)
        apply("R9 base", a, b, od, 2'd0, 2'd2, 16'h0005, 1'b1, 1'b0);
        r0 = res_o;
        apply("R9 high mask bits", a, b, od, 2'd0, 2'd2, 16'hFFF5, 1'b1, 1'b0);
        check("R9 unchanged", res_o, r0);
        apply("R9 vl256 base", a, b, od, 2'd1, 2'd2, 16'h00A6, 1'b0, 1'b1);
        r0 = res_o;
        apply("R9 vl256 high bits", a, b, od, 2'd1, 2'd2, 16'hFFA6, 1'b0, 1'b1);
        check("R9 vl256 unchanged", res_o, r0);

        // Ignored controls in plain and legacy mode (R7, R8)
        apply("R7 base", a, b, od, 2'd2, 2'd1, '0, 1'b0, 1'b0);
        r0 = res_o;
        apply("R7 ctl flipped", a, b, od, 2'd2, 2'd1, '1, 1'b1, 1'b1);
        check("R7 unchanged", res_o, r0);
        apply("R8 base", a, b, od, 2'd0, 2'd0, '0, 1'b0, 1'b0);
        r0 = res_o;
        apply("R8 ctl flipped", a, b, od, 2'd2, 2'd0, '1, 1'b1, 1'b1);
        check("R8 unchanged", res_o, r0);

        // Hold while idle (R10)
        r0 = res_o;
        @(negedge clk);
        src_a_i = rnd_vec(); src_b_i = rnd_vec(); old_i = rnd_vec(); mode_i = 2'd1;
        @(negedge clk);
        check1("R10 idle vld", vld_o, 1'b0);
        check("R10 idle hold", res_o, r0);

        // Reset mid-run (R11)
        b2 = rnd_vec();
        apply("R11 pre", a, b2, od, 2'd2, 2'd1, '0, 1'b0, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check1("R11 vld cleared", vld_o, 1'b0);
        check("R11 res cleared", res_o, '0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule